// File: doc/BRIEF.md
# Serialized Interrupt Peripheral Agent

This block is the peripheral side of a single-wire, open-drain interrupt bus that shares the system clock. The host opens each bus cycle by pulling the line low for several clocks. The agent watches for that low pulse and for the clock on which the line comes back high. Starting from that clock it counts a train of three-clock frames, one frame for each interrupt slot. In the slot of every active-low interrupt that is asserted, the agent pulls the line low for one clock, drives it high for one clock, and then lets go. At the end of each train the host sends a short closing low pulse. Its width sets the bus mode for the next cycle.

The agent starts up in continuous mode. In that mode only the host may begin a bus cycle. When a closing pulse has put the bus into quiet mode, the agent may ask for a cycle itself. It does this by pulling the idle line low for one clock whenever its interrupt levels differ from the values it last sent. The host then continues that low pulse into a full start pulse. Slot 3 carries either interrupt bit 2 or a system-management request, chosen by an enable input. Slot 1 is never driven.

Outside logic combines the two drive enables with a pull-up to form the wire. The agent reads back the resolved level on `lineIn`.

Top module: `sirq_agent`

## Requirements
- R1: After reset both drive enables are 0 and the bus is in continuous mode: a change on the interrupt inputs while the bus idles does not make the agent drive the line.
- R2: The rising edge of a start pulse is the first clock on which `lineIn` reads 1 after having read 0. Call that clock 0. The Sample clock of slot N is then clock 3N−1. On that clock `driveLow` is 1 exactly when the latched value of slot N is 0. Slot N is bit N−1 of `irqN`, and the bit is active low.
- R3: `driveHigh` is 1 on the clock just after a Sample clock on which the agent drove low (clock 3N), and on no other clock.
- R4: On each Turn-around clock (3N+1), on the clock before slot 1 (clock 1), and throughout the start and stop pulses, both enables are 0.
- R5: The agent latches the slot values on clock 0. A change on the inputs after that clock does not affect the current bus cycle.
- R6: The agent never drives slot 1, whatever the value of `irqN[0]`.
- R7: When `smiEn` is 1, slot 3 carries `smiN` and ignores `irqN[2]`. When `smiEn` is 0, slot 3 carries `irqN[2]` and ignores `smiN`.
- R8: After the last slot, the agent measures the low width of the next closing pulse. A width of 2 clocks selects quiet mode, 3 clocks selects continuous mode, and any other width keeps the current mode. The mode changes at no other time.
- R9: In quiet mode, on an idle bus, if the effective slot values differ from the values last latched, the agent drives `driveLow` for exactly one clock. It then treats the cycle as a start pulse.
- R10: The agent drives its slots in the same way whether the host or the agent began the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineIn | input | 1 | Resolved level of the bus wire |
| irqN | input | SLOTS | Active-low interrupt level for each slot; bit i belongs to slot i+1 |
| smiN | input | 1 | Active-low system-management request |
| smiEn | input | 1 | Routes `smiN` onto slot 3 in place of `irqN[2]` |
| driveLow | output | 1 | Pull the wire low this clock |
| driveHigh | output | 1 | Drive the wire high this clock |

## Verification
The bench drives the host side of the wire. A behavioural model predicts both enables on every clock. The bench aims at these cases:
- An off-by-one in the slot count. This would move every drive to the wrong clock, and the per-clock compare flags it on the first active slot.
- A change on the inputs in the middle of a bus cycle. If the agent sampled its inputs live instead of latching them, the number of drive-low clocks in that cycle would be wrong.
- Closing pulses of width 2, 5 and 3, each followed by a change on an input. These expose a design that decodes the mode wrongly or changes it on an unexpected width: it would either miss the one-clock start request or raise one in continuous mode.
- Slot 1 held asserted and slot 3 switched between the two sources. These catch a design that drives the unused slot or picks the wrong source.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  // Width of a slot index; supports up to 63 slots.
  localparam int SLOT_W = 6;
  typedef logic [SLOT_W-1:0] slotIdx_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_START,
    ST_DATA,
    ST_STOP
  } agentState_e;

  // Phase within one three-clock slot frame.
  typedef enum logic [1:0] {
    PH_SAMPLE,
    PH_RECOVER,
    PH_TURN
  } framePhase_e;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic     latchNow;   // rising edge of start pulse seen this clock
    logic     samplePh;   // Sample phase of slot `slot`
    logic     recoverPh;  // Recovery phase of slot `slot`
    logic     turnPh;     // Turn-around (or pre-slot) clock
    logic     reqStart;   // one-clock start request in quiet mode
    slotIdx_t slot;       // current slot, 1-based; 0 before slot 1
  } sirqStrobe_t;

endpackage

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int QUIET_W = 2,
  parameter int CONT_W  = 3,
  parameter int WCNT_W  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineIn,
  input  logic        pending,
  output sirqStrobe_t strb,
  output logic        quietMode
);

  localparam slotIdx_t LAST_SLOT = slotIdx_t'(SLOTS);
  localparam logic [WCNT_W-1:0] QUIET_CODE = WCNT_W'(QUIET_W);
  localparam logic [WCNT_W-1:0] CONT_CODE  = WCNT_W'(CONT_W);

  agentState_e       state;
  framePhase_e       phase;
  slotIdx_t          slot;
  logic [WCNT_W-1:0] stopWidth;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= PH_TURN;
      slot      <= '0;
      stopWidth <= '0;
      quietMode <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!lineIn) state <= ST_START;
          else if (quietMode && pending) state <= ST_REQ;
        end
        ST_REQ: state <= ST_START;
        ST_START: begin
          if (lineIn) begin
            state <= ST_DATA;
            phase <= PH_TURN;   // clock 1: lead-in before slot 1
            slot  <= '0;
          end
        end
        ST_DATA: begin
          case (phase)
            PH_SAMPLE:  phase <= PH_RECOVER;
            PH_RECOVER: phase <= PH_TURN;
            default: begin
              if (slot == LAST_SLOT) begin
                state     <= ST_STOP;
                stopWidth <= '0;
              end else begin
                phase <= PH_SAMPLE;
                slot  <= slot + 1'b1;
              end
            end
          endcase
        end
        ST_STOP: begin
          if (!lineIn) begin
            if (stopWidth != '1) stopWidth <= stopWidth + 1'b1;
          end else if (stopWidth != '0) begin
            if (stopWidth == QUIET_CODE) quietMode <= 1'b1;
            else if (stopWidth == CONT_CODE) quietMode <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.latchNow  = (state == ST_START) && lineIn;
    strb.samplePh  = (state == ST_DATA) && (phase == PH_SAMPLE);
    strb.recoverPh = (state == ST_DATA) && (phase == PH_RECOVER);
    strb.turnPh    = (state == ST_DATA) && (phase == PH_TURN);
    strb.reqStart  = (state == ST_REQ);
    strb.slot      = slot;
  end

  // R8: mode only moves while a closing pulse is being measured
  a_r8_mode_only_in_stop: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_STOP) |=> $stable(quietMode));

  // R9: a start request is raised only in quiet mode and lasts one clock
  a_r9_req_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strb.reqStart |-> quietMode);
  a_r9_req_single: assert property (@(posedge clk) disable iff (!rstN)
    strb.reqStart |=> !strb.reqStart);

  // R2: sample slots stay within the configured range
  a_r2_slot_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.samplePh |-> (slot != '0) && (slot <= LAST_SLOT));

endmodule

// File: rtl/sirq_dpath.sv
module sirq_dpath
  import sirq_pkg::*;
#(
  parameter int SLOTS    = 16,
  parameter int SMI_SLOT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SLOTS-1:0] irqN,
  input  logic             smiN,
  input  logic             smiEn,
  input  sirqStrobe_t      strb,
  output logic             pending,
  output logic             driveLow,
  output logic             driveHigh
);

  logic [SLOTS-1:0] effN;
  logic [SLOTS-1:0] latchN;
  logic             selBit;
  logic             sampleDrive;
  logic             lowPrev;

  // Effective slot values: slot 1 is never used; one slot may carry SMI.
  for (genvar g = 0; g < SLOTS; g++) begin : gEff
    if (g == 0) begin : gUnused
      assign effN[g] = irqN[g] | 1'b1;
    end else if (g == SMI_SLOT - 1) begin : gSmi
      assign effN[g] = smiEn ? smiN : irqN[g];
    end else begin : gIrq
      assign effN[g] = irqN[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchN  <= '1;
      lowPrev <= 1'b0;
    end else begin
      if (strb.latchNow) latchN <= effN;
      lowPrev <= sampleDrive;
    end
  end

  always_comb begin
    selBit = 1'b1;
    for (int i = 0; i < SLOTS; i++) begin
      if (strb.slot == SLOT_W'(i + 1)) selBit = latchN[i];
    end
  end

  assign pending     = (effN != latchN);
  assign sampleDrive = strb.samplePh && !selBit;
  assign driveLow    = strb.reqStart || sampleDrive;
  assign driveHigh   = strb.recoverPh && lowPrev;

  // R3: a high drive only restores a line this agent pulled low
  a_r3_restore_after_low: assert property (@(posedge clk) disable iff (!rstN)
    driveHigh |-> $past(driveLow));
  a_r3_low_then_high: assert property (@(posedge clk) disable iff (!rstN)
    (strb.samplePh && driveLow) |=> driveHigh);

  // R4: the turn-around clock releases the line; no clock drives both ways
  a_r4_turn_release: assert property (@(posedge clk) disable iff (!rstN)
    strb.turnPh |-> (!driveLow && !driveHigh));
  a_r4_no_fight: assert property (@(posedge clk) disable iff (!rstN)
    !(driveLow && driveHigh));

  // R6: slot 1 sample never drives
  a_r6_slot1_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (strb.samplePh && strb.slot == SLOT_W'(1)) |-> !driveLow);

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_pkg::*;
#(
  parameter int SLOTS    = 16,
  parameter int SMI_SLOT = 3,
  parameter int QUIET_W  = 2,
  parameter int CONT_W   = 3,
  parameter int WCNT_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  logic [SLOTS-1:0] irqN,
  input  logic             smiN,
  input  logic             smiEn,
  output logic             driveLow,
  output logic             driveHigh
);

  sirqStrobe_t strb;
  logic        pending;
  logic        quietMode;

  sirq_ctrl #(
    .SLOTS  (SLOTS),
    .QUIET_W(QUIET_W),
    .CONT_W (CONT_W),
    .WCNT_W (WCNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .pending  (pending),
    .strb     (strb),
    .quietMode(quietMode)
  );

  sirq_dpath #(
    .SLOTS   (SLOTS),
    .SMI_SLOT(SMI_SLOT)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .irqN     (irqN),
    .smiN     (smiN),
    .smiEn    (smiEn),
    .strb     (strb),
    .pending  (pending),
    .driveLow (driveLow),
    .driveHigh(driveHigh)
  );

  // R9: outside a data train, a low drive is always a quiet-mode request
  a_r9_idle_drive_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (driveLow && !strb.samplePh) |-> quietMode);

endmodule

// File: tb/sim_sirq_agent.sv
module sim_sirq_agent;

  localparam int SLOTS = 16;
  localparam int LAST_CNT = 3 * SLOTS + 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [SLOTS-1:0] irqN = '1;
  logic             smiN = 1'b1;
  logic             smiEn = 1'b0;
  logic             hostLow = 1'b0;
  logic             lineIn;
  logic             driveLow, driveHigh;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  assign lineIn = !(hostLow || driveLow);

  sirq_agent #(.SLOTS(SLOTS)) u0 (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .irqN(irqN),
    .smiN(smiN), .smiEn(smiEn), .driveLow(driveLow), .driveHigh(driveHigh)
  );

  function automatic logic [SLOTS-1:0] effOf();
    logic [SLOTS-1:0] v;
    v = irqN;
    v[0] = 1'b1;
    v[2] = smiEn ? smiN : irqN[2];
    return v;
  endfunction

  function automatic int lowsIn(logic [SLOTS-1:0] v);
    int n = 0;
    for (int i = 1; i < SLOTS; i++) if (!v[i]) n++;
    return n;
  endfunction

  // ---------------- reference model ----------------
  // 0 idle, 1 request, 2 start pulse, 3 slot train, 4 closing pulse
  int               mState = 0;
  int               mCnt = 0;
  int               mStopLow = 0;
  bit               mQuiet = 1'b0;
  logic [SLOTS-1:0] mLatch = '1;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mStopLow = 0; mQuiet = 1'b0; mLatch = '1;
    end else begin
      case (mState)
        0: if (!lineIn) mState = 2;
           else if (mQuiet && effOf() != mLatch) mState = 1;
        1: mState = 2;
        2: if (lineIn) begin mState = 3; mCnt = 1; mLatch = effOf(); end
        3: if (mCnt == LAST_CNT) begin mState = 4; mStopLow = 0; end
           else mCnt++;
        default: begin
          if (!lineIn) mStopLow++;
          else if (mStopLow > 0) begin
            if (mStopLow == 2) mQuiet = 1'b1;
            else if (mStopLow == 3) mQuiet = 1'b0;
            mState = 0;
          end
        end
      endcase
    end
  end

  task automatic expectNow(output logic eLow, output logic eHigh, output string tag);
    eLow = 1'b0; eHigh = 1'b0; tag = "R4";
    if (mState == 1) begin
      eLow = 1'b1; tag = "R9";
    end else if (mState == 3) begin
      if (mCnt >= 2 && (mCnt - 2) % 3 == 0) begin
        int n = (mCnt + 1) / 3;
        eLow = !mLatch[n-1];
        tag = (n == 1) ? "R6" : (n == 3) ? "R7" : "R2";
      end else if (mCnt >= 3 && mCnt % 3 == 0) begin
        int n = mCnt / 3;
        eHigh = !mLatch[n-1];
        tag = "R3";
      end
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic eL, eH;
      string tg;
      expectNow(eL, eH, tg);
      checks++;
      if (driveLow !== eL || driveHigh !== eH) begin
        errors++;
        $display("FAIL %s cycle %0d: low/high=%b%b expected %b%b", tg, cycles,
                 driveLow, driveHigh, eL, eH);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Count agent low drives over the slot train after the start pulse ends.
  task automatic countTrain(input int changeAt, input logic [SLOTS-1:0] newVal,
                            output int lows);
    lows = 0;
    for (int i = 0; i < LAST_CNT + 3; i++) begin
      @(negedge clk);
      if (driveLow) lows++;
      if (i == changeAt) irqN = newVal;
    end
  endtask

  task automatic closePulse(input int w);
    hostLow = 1'b1;
    waitNeg(w);
    hostLow = 1'b0;
    waitNeg(3);
  endtask

  task automatic hostCycle(input int startW, input int stopW, input int changeAt,
                           input logic [SLOTS-1:0] newVal, output int lows);
    @(negedge clk);
    hostLow = 1'b1;
    waitNeg(startW);
    hostLow = 1'b0;
    countTrain(changeAt, newVal, lows);
    closePulse(stopW);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : main
    int lows;
    logic [SLOTS-1:0] v;
    waitNeg(3);
    check(driveLow === 1'b0 && driveHigh === 1'b0, "R1 reset outputs",
          {driveLow, driveHigh}, 0);
    rstN = 1'b1;
    waitNeg(2);

    // R1: continuous after reset, a change does not start a cycle
    irqN[5] = 1'b0;
    waitNeg(6);
    check(driveLow === 1'b0, "R1 no request in continuous", driveLow, 0);

    // R2 R6 R10: host-started cycle, slot 1 asserted but unused
    irqN = 16'b1010_1101_0110_1010;
    v = effOf();
    hostCycle(4, 3, -1, '1, lows);
    check(lows == lowsIn(v), "R2 R6 R10 host cycle low count", lows, lowsIn(v));

    // R5: inputs change mid-train, latched values rule the cycle
    irqN = 16'b1111_0111_1011_1101;
    v = effOf();
    hostCycle(6, 3, 10, 16'h0000, lows);
    check(lows == lowsIn(v), "R5 latched at start edge", lows, lowsIn(v));

    // R7: SMI routed onto slot 3
    irqN = '1; smiEn = 1'b1; smiN = 1'b0;
    hostCycle(5, 3, -1, '1, lows);
    check(lows == 1, "R7 smi on slot 3", lows, 1);
    irqN = 16'hFFFB; smiEn = 1'b0; smiN = 1'b0;
    hostCycle(5, 3, -1, '1, lows);
    check(lows == 1, "R7 irq2 on slot 3 smi ignored", lows, 1);
    irqN = '1; smiN = 1'b1;
    hostCycle(8, 2, -1, '1, lows);  // width 2 -> quiet (R8)
    check(lows == 0, "R7 released slot 3", lows, 0);

    // R9 R8: quiet mode, agent requests a start after a change
    irqN[9] = 1'b0;
    @(negedge clk);
    check(driveLow === 1'b1, "R9 R8 start request in quiet", driveLow, 1);
    hostLow = 1'b1;
    waitNeg(1);
    check(driveLow === 1'b0, "R9 request lasts one clock", driveLow, 0);
    waitNeg(2);
    hostLow = 1'b0;
    v = effOf();
    countTrain(-1, '1, lows);
    check(lows == lowsIn(v), "R10 agent-started cycle", lows, lowsIn(v));
    closePulse(5);  // width 5 keeps quiet (R8)

    irqN[9] = 1'b1;
    @(negedge clk);
    check(driveLow === 1'b1, "R8 odd width keeps quiet", driveLow, 1);
    hostLow = 1'b1;
    waitNeg(3);
    hostLow = 1'b0;
    countTrain(-1, '1, lows);
    check(lows == 0, "R10 cycle with no asserted slot", lows, 0);
    closePulse(3);  // width 3 -> continuous (R8)

    irqN[12] = 1'b0;
    waitNeg(8);
    check(driveLow === 1'b0, "R8 width 3 back to continuous", driveLow, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule